// File: doc/BRIEF.md
# Transmit Descriptor Gather Engine

This block fetches outgoing frames that software has scattered across host memory. Software lays out a ring of 8-byte descriptors. Each descriptor points at one fragment buffer. Software then pulses a kick input. The engine starts at its current ring index and reads each descriptor through a word-wide memory master port. It copies the fragment bytes, from any byte alignment, into a local staging buffer. It then writes the descriptor back to mark it consumed.

When a fragment carries the last-fragment flag, the engine plays the staged bytes out as one frame on a byte stream with valid, ready and last. It then ends the walk and raises a transmit interrupt status bit. A frame too large for the staging buffer is dropped. The error flag is set in its write-back.

A ring-clear control returns the ring index and the staging offset to zero. Software uses it to restart the ring.

Top module: `txg_engine`

## Requirements
- R1: Descriptor i sits at ring_base + 8*i. Word 0 holds the 32-bit fragment buffer address. Word 1 bits 15:0 hold the fragment length minus one. Word 1 bits 31:16 hold the flags: bit 15 (flag bit 15) is valid and bit 0 is last-fragment.
- R2: On a kick the engine starts at its current index and examines at most ring_size_m1+1 descriptors. The index wraps from ring_size_m1 to 0. The walk stops at the first descriptor whose valid flag is clear, and that descriptor is left unwritten.
- R3: Each serviced descriptor appends its length plus one bytes, in address order, at the current staging offset. The bytes are read from its buffer address, which may have any byte alignment.
- R4: Each serviced descriptor's word 1 is rewritten with the length field plus 5 (modulo 2^16). Flag bits 15 down to 9 are cleared. Flag bits 8 down to 0 are kept.
- R5: After write-back of a descriptor with the last flag, every staged byte is emitted in order on the stream, with out_last on the final byte. The staging offset returns to zero and the walk ends. No memory request is made while the stream is valid.
- R6: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold.
- R7: tx_irq rises only on the cycle after the last byte of a frame is accepted. It stays high until irq_clear is pulsed. A walk that emits no frame leaves it unchanged.
- R8: A ring_clear pulse while idle sets the ring index and the staging offset to zero, so bytes staged earlier are discarded.
- R9: If a fragment would push the staged total past STAGE_BYTES, its bytes are not fetched. The partial frame is discarded and the offset goes to zero. Its write-back sets the error flag (flag bit 14). If that descriptor is last, the walk ends with no frame. A frame of exactly STAGE_BYTES bytes is sent.
- R10: A memory request holds its address, direction and write data until mem_ack.
- R11: After reset, busy, mem_req, out_valid and tx_irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kick | input | 1 | Start a ring walk (pulse, taken while idle) |
| ring_clear | input | 1 | Zero ring index and staging offset (taken while idle) |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| ring_size_m1 | input | IDX_W | Number of ring entries minus one |
| irq_clear | input | 1 | Clear the transmit interrupt status |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data, byte 0 in bits 7:0 |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of frame |
| out_ready | input | 1 | Stream sink ready |
| tx_irq | output | 1 | Transmit interrupt status |
| busy | output | 1 | Walk in progress |

## Verification
The bench builds the engine with a 64-byte staging buffer and a 3-bit index, and runs a four-entry ring. The small buffer lets a 50-byte plus 20-byte frame overflow it, and lets a single 64-byte fragment fill it exactly. The short ring makes the index wrap and the walk limit appear within a few kicks. Unaligned buffers and a toggling ready exercise byte lane unpacking and stream back-pressure.

// File: rtl/txg_pkg.sv
// Shared constants and types for the transmit gather engine.
package txg_pkg;
    localparam int FLG_VALID = 15;
    localparam int FLG_ERR   = 14;
    localparam int FLG_LAST  = 0;
    // valid, error, underflow, late collision, carrier lost, deferred, retry
    localparam logic [15:0] FLG_CLEAR_MASK = 16'hFE00;
    localparam logic [15:0] LEN_WB_BIAS    = 16'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RD_BUF,
        ST_RD_CTL,
        ST_FETCH,
        ST_UNPACK,
        ST_WB,
        ST_SEND
    } txg_state_e;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] len_m1;
    } txg_ctl_t;
endpackage

// File: rtl/txg_ring_ptr.sv
// Ring index register and descriptor address.
// Assumes size_m1 is stable during a walk; index wraps to zero after size_m1.
module txg_ring_ptr #(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [IDX_W-1:0]  size_m1,
    input  logic [ADDR_W-1:0] base,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] desc_addr
);
    // Index update: clear, or step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx <= '0;
        end else if (advance) begin
            idx <= (idx >= size_m1) ? '0 : idx + 1'b1;
        end
    end

    // Each descriptor occupies eight bytes.
    always_comb begin
        desc_addr = base + (ADDR_W'(idx) << 3);
    end
endmodule

// File: rtl/txg_stage_ram.sv
// Byte-wide staging memory: one synchronous write port, one combinational read port.
// Assumes the writer never addresses beyond DEPTH-1.
module txg_stage_ram #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Store one staged byte.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read port feeding the stream.
    always_comb begin
        rdata = mem[raddr];
    end
endmodule

// File: rtl/txg_stream_out.sv
// Plays staged bytes 0..frame_len-1 out on a valid/ready byte stream.
// Assumes frame_len >= 1 and that start arrives only while inactive.
module txg_stream_out #(
    parameter int AW    = 11,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    output logic [AW-1:0]    rd_addr,
    input  logic [7:0]       rd_data,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic             out_ready,
    output logic             done
);
    logic             active;
    logic [LEN_W-1:0] left;

    // Sequence through the frame bytes as the sink accepts them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            left    <= '0;
            rd_addr <= '0;
        end else if (start) begin
            active  <= 1'b1;
            left    <= frame_len;
            rd_addr <= '0;
        end else if (active && out_ready) begin
            if (left == LEN_W'(1)) begin
                active <= 1'b0;
            end else begin
                left    <= left - 1'b1;
                rd_addr <= rd_addr + 1'b1;
            end
        end
    end

    // Stream outputs and end-of-frame strobe.
    always_comb begin
        out_valid = active;
        out_data  = rd_data;
        out_last  = active && (left == LEN_W'(1));
        done      = active && out_ready && (left == LEN_W'(1));
    end
endmodule

// File: rtl/txg_engine.sv
// Transmit descriptor gather engine (top).
// Walks the descriptor ring on a kick, gathers fragments into staging,
// writes each descriptor back, and streams the frame on its last fragment.
// Assumes one outstanding memory request, completed by mem_ack with read data.
module txg_engine
    import txg_pkg::*;
#(
    parameter int STAGE_BYTES = 2048,
    parameter int IDX_W       = 8,
    parameter int ADDR_W      = 32,
    localparam int SAW        = $clog2(STAGE_BYTES),
    localparam int OFF_W      = $clog2(STAGE_BYTES + 1),
    localparam int CNT_W      = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic              ring_clear,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W-1:0]  ring_size_m1,
    input  logic              irq_clear,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              tx_irq,
    output logic              busy
);
    txg_state_e        state;
    txg_ctl_t          ctl;
    txg_ctl_t          ctl_rd;
    logic [ADDR_W-1:0] cur_addr;
    logic [31:0]       word_q;
    logic [1:0]        lane;
    logic [16:0]       remain;
    logic [16:0]       need;
    logic [OFF_W-1:0]  offset;
    logic              ovf;
    logic [CNT_W-1:0]  examined;
    logic [CNT_W-1:0]  ring_len;
    logic              fits;

    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] desc_addr;
    logic              ptr_clear;
    logic              ptr_adv;

    logic              st_we;
    logic [7:0]        st_wdata;
    logic [SAW-1:0]    st_raddr;
    logic [7:0]        st_rdata;
    logic              strm_start;
    logic              strm_done;
    logic [15:0]       wb_flags;

    txg_ring_ptr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ptr_clear),
        .advance   (ptr_adv),
        .size_m1   (ring_size_m1),
        .base      (ring_base),
        .idx       (idx),
        .desc_addr (desc_addr)
    );

    txg_stage_ram #(.DEPTH(STAGE_BYTES)) u_ram (
        .clk   (clk),
        .we    (st_we),
        .waddr (offset[SAW-1:0]),
        .wdata (st_wdata),
        .raddr (st_raddr),
        .rdata (st_rdata)
    );

    txg_stream_out #(.AW(SAW), .LEN_W(OFF_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (strm_start),
        .frame_len (offset),
        .rd_addr   (st_raddr),
        .rd_data   (st_rdata),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_ready (out_ready),
        .done      (strm_done)
    );

    // Decode the fetched control word and check the staging room.
    always_comb begin
        ctl_rd   = txg_ctl_t'(mem_rdata);
        need     = {1'b0, ctl_rd.len_m1} + 17'd1;
        fits     = (18'(offset) + 18'(need)) <= 18'(STAGE_BYTES);
        ring_len = CNT_W'(ring_size_m1) + CNT_W'(1);
        wb_flags = (ctl.flags & ~FLG_CLEAR_MASK) | (ovf ? (16'd1 << FLG_ERR) : 16'd0);
    end

    // Memory request, staging write and pointer control per state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = 32'd0;
        case (state)
            ST_RD_BUF: mem_req = 1'b1;
            ST_RD_CTL: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(4);
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = {cur_addr[ADDR_W-1:2], 2'b00};
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + ADDR_W'(4);
                mem_wdata = {wb_flags, ctl.len_m1 + LEN_WB_BIAS};
            end
            default: ;
        endcase
        st_we      = (state == ST_UNPACK);
        st_wdata   = word_q[{lane, 3'b000} +: 8];
        ptr_clear  = (state == ST_IDLE) && ring_clear;
        ptr_adv    = (state == ST_WB) && mem_ack;
        strm_start = (state == ST_WB) && mem_ack && ctl.flags[FLG_LAST] && !ovf;
        busy       = (state != ST_IDLE);
    end

    // Walk sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ctl      <= '0;
            cur_addr <= '0;
            word_q   <= '0;
            lane     <= '0;
            remain   <= '0;
            offset   <= '0;
            ovf      <= 1'b0;
            examined <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ring_clear) begin
                        offset <= '0;
                    end
                    if (kick) begin
                        examined <= '0;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    state <= (examined == ring_len) ? ST_IDLE : ST_RD_BUF;
                end
                ST_RD_BUF: begin
                    if (mem_ack) begin
                        cur_addr <= mem_rdata[ADDR_W-1:0];
                        state    <= ST_RD_CTL;
                    end
                end
                ST_RD_CTL: begin
                    if (mem_ack) begin
                        ctl <= ctl_rd;
                        if (!ctl_rd.flags[FLG_VALID]) begin
                            state <= ST_IDLE;
                        end else begin
                            examined <= examined + 1'b1;
                            if (fits) begin
                                ovf    <= 1'b0;
                                remain <= need;
                                state  <= ST_FETCH;
                            end else begin
                                ovf    <= 1'b1;
                                offset <= '0;
                                state  <= ST_WB;
                            end
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        word_q <= mem_rdata;
                        lane   <= cur_addr[1:0];
                        state  <= ST_UNPACK;
                    end
                end
                ST_UNPACK: begin
                    offset   <= offset + 1'b1;
                    cur_addr <= cur_addr + 1'b1;
                    remain   <= remain - 1'b1;
                    lane     <= lane + 1'b1;
                    if (remain == 17'd1) begin
                        state <= ST_WB;
                    end else if (lane == 2'd3) begin
                        state <= ST_FETCH;
                    end
                end
                ST_WB: begin
                    if (mem_ack) begin
                        if (!ctl.flags[FLG_LAST]) begin
                            state <= ST_CHECK;
                        end else if (ovf) begin
                            state <= ST_IDLE;
                        end else begin
                            offset <= '0;
                            state  <= ST_SEND;
                        end
                    end
                end
                ST_SEND: begin
                    if (strm_done) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Transmit interrupt status: set on frame completion, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_irq <= 1'b0;
        end else if (strm_done) begin
            tx_irq <= 1'b1;
        end else if (irq_clear) begin
            tx_irq <= 1'b0;
        end
    end
endmodule

// File: rtl/txg_engine_chk.sv
// Protocol and status checks for txg_engine, attached by bind.
module txg_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              out_last,
    input logic              tx_irq,
    input logic              irq_clear,
    input logic              busy
);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    assert_wb_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31] && (mem_wdata[29:25] == 5'd0));

    assert_stream_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    assert_stream_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_req);

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_irq) |-> $past(out_valid && out_ready && out_last));

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq && !irq_clear |=> tx_irq);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid && !mem_req);
endmodule

bind txg_engine txg_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .tx_irq    (tx_irq),
    .irq_clear (irq_clear),
    .busy      (busy)
);

// File: tb/txg_engine_test.sv
`timescale 1ns/1ps
module txg_engine_test;
    localparam int STAGE = 64;
    localparam int IW    = 3;
    localparam logic [31:0] BASE = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kick = 1'b0;
    logic        ring_clear = 1'b0;
    logic        irq_clear = 1'b0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 32'd0;
    logic        out_valid, out_last, out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        tx_irq, busy;
    logic        stall_mode = 1'b0;

    logic [31:0] mem [1024];
    logic [7:0]  rx_data [4096];
    int          rx_cnt = 0;
    int          frames = 0;
    int          ring_rd = 0;
    logic [7:0]  exp_q [256];
    int          exp_n;
    int          n_tests = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    txg_engine #(.STAGE_BYTES(STAGE), .IDX_W(IW), .ADDR_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .kick(kick), .ring_clear(ring_clear),
        .ring_base(BASE), .ring_size_m1(3'd3), .irq_clear(irq_clear),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .tx_irq(tx_irq), .busy(busy)
    );

    // Memory model: acknowledges one cycle after a request appears.
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            mem_rdata <= mem[mem_addr[11:2]];
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            if (!mem_we && mem_addr >= BASE && mem_addr < BASE + 32'd32) ring_rd <= ring_rd + 1;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Stream sink.
    always @(posedge clk) begin
        if (out_valid && out_ready) begin
            rx_data[rx_cnt] <= out_data;
            rx_cnt <= rx_cnt + 1;
            if (out_last) frames <= frames + 1;
        end
    end

    always @(negedge clk) out_ready <= stall_mode ? ~out_ready : 1'b1;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) ^ (a >> 8));
    endfunction

    task automatic put_byte(input int a, input logic [7:0] v);
        mem[a >> 2][8*(a & 3) +: 8] = v;
    endtask

    task automatic fill(input int a, input int n);
        for (int i = 0; i < n; i++) put_byte(a + i, pat(a + i));
    endtask

    task automatic put_desc(input int i, input int b, input int len_m1, input logic [15:0] fl);
        mem[(BASE + 8 * i) >> 2]     = 32'(b);
        mem[((BASE + 8 * i) >> 2) + 1] = {fl, 16'(len_m1)};
    endtask

    function automatic logic [31:0] ctl_word(input int i);
        return mem[((BASE + 8 * i) >> 2) + 1];
    endfunction

    task automatic add_exp(input int a, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q[exp_n] = pat(a + i);
            exp_n++;
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_kick;
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_irq_clear;
        @(negedge clk) irq_clear = 1'b1;
        @(negedge clk) irq_clear = 1'b0;
    endtask

    // Compare frame bytes received since start index against exp_q.
    task automatic chk_frame(input int start, input string req);
        int bad = 0;
        chk(rx_cnt - start == exp_n, req, 32'(rx_cnt - start), 32'(exp_n));
        for (int i = 0; i < exp_n; i++)
            if (rx_data[start + i] !== exp_q[i]) bad++;
        chk(bad == 0, req, 32'(bad), 32'd0);
    endtask

    task automatic t_reset;
        chk(!busy && !mem_req && !out_valid && !tx_irq, "R11",
            {28'd0, busy, mem_req, out_valid, tx_irq}, 32'd0);
    endtask

    // R1 R3 R4 R5 R7: one aligned single-fragment frame with error bits preset.
    task automatic t_single;
        int s = rx_cnt;
        fill(32'h200, 10);
        put_desc(0, 32'h200, 9, 16'hFE41);
        put_desc(1, 32'h210, 3, 16'h0000);
        exp_n = 0; add_exp(32'h200, 10);
        do_kick;
        chk_frame(s, "R5 single");
        chk(ctl_word(0) == 32'h0041000E, "R4 single", ctl_word(0), 32'h0041000E);
        chk(tx_irq, "R7 set", {31'd0, tx_irq}, 32'd1);
        pulse_irq_clear;
        chk(!tx_irq, "R7 clear", {31'd0, tx_irq}, 32'd0);
    endtask

    // R3 R6: unaligned fragments with back-pressure.
    task automatic t_multi;
        int s = rx_cnt;
        stall_mode = 1'b1;
        fill(32'h203, 5); fill(32'h301, 3);
        put_desc(1, 32'h203, 4, 16'h8000);
        put_desc(2, 32'h301, 2, 16'h8001);
        exp_n = 0; add_exp(32'h203, 5); add_exp(32'h301, 3);
        do_kick;
        stall_mode = 1'b0;
        chk_frame(s, "R3 R6 unaligned");
        chk(ctl_word(1) == 32'h00000009, "R4 mid", ctl_word(1), 32'h00000009);
        chk(ctl_word(2) == 32'h00010007, "R4 last", ctl_word(2), 32'h00010007);
        pulse_irq_clear;
    endtask

    // R2: index wraps from 3 to 0 within one walk.
    task automatic t_wrap;
        int s = rx_cnt;
        fill(32'h240, 2); fill(32'h250, 1);
        put_desc(3, 32'h240, 1, 16'h8000);
        put_desc(0, 32'h250, 0, 16'h8001);
        exp_n = 0; add_exp(32'h240, 2); add_exp(32'h250, 1);
        do_kick;
        chk_frame(s, "R2 wrap");
        chk(ctl_word(0) == 32'h00010005, "R2 wrap wb", ctl_word(0), 32'h00010005);
        pulse_irq_clear;
    endtask

    // R2 R7 R8: walk bounded by ring size, no frame, then clear drops leftovers.
    task automatic t_exhaust_clear;
        int s = rx_cnt;
        int f = frames;
        int r0 = ring_rd;
        for (int i = 0; i < 4; i++) begin
            fill(32'h260 + 4 * i, 1);
            put_desc((i + 1) % 4, 32'h260 + 4 * i, 0, 16'h8000);
        end
        do_kick;
        chk(ring_rd - r0 == 8, "R2 bound", 32'(ring_rd - r0), 32'd8);
        chk(frames == f, "R7 no frame", 32'(frames), 32'(f));
        chk(!tx_irq, "R7 no irq", {31'd0, tx_irq}, 32'd0);
        chk(ctl_word(3) == 32'h00000005, "R4 plain", ctl_word(3), 32'h00000005);
        @(negedge clk) ring_clear = 1'b1;
        @(negedge clk) ring_clear = 1'b0;
        fill(32'h280, 2);
        put_desc(0, 32'h280, 1, 16'h8001);
        exp_n = 0; add_exp(32'h280, 2);
        s = rx_cnt;
        do_kick;
        chk_frame(s, "R8 clear");
        pulse_irq_clear;
    endtask

    // R2: invalid descriptor stops the walk untouched.
    task automatic t_invalid;
        int f = frames;
        int r0 = ring_rd;
        put_desc(1, 32'h2A0, 7, 16'h0001);
        do_kick;
        chk(ctl_word(1) == 32'h00010007, "R2 invalid untouched", ctl_word(1), 32'h00010007);
        chk(frames == f && ring_rd - r0 == 2, "R2 invalid stop", 32'(ring_rd - r0), 32'd2);
        chk(!tx_irq, "R7 invalid", {31'd0, tx_irq}, 32'd0);
    endtask

    // R9: overflow drop, recovery, then exact-fill frame.
    task automatic t_overflow;
        int f = frames;
        int s;
        fill(32'h300, 50); fill(32'h340, 20);
        put_desc(1, 32'h300, 49, 16'h8000);
        put_desc(2, 32'h340, 19, 16'h8001);
        do_kick;
        chk(ctl_word(1) == 32'h00000036, "R9 first", ctl_word(1), 32'h00000036);
        chk(ctl_word(2) == 32'h40010018, "R9 error flag", ctl_word(2), 32'h40010018);
        chk(frames == f && !tx_irq, "R9 dropped", 32'(frames - f), 32'd0);
        fill(32'h380, 3);
        put_desc(3, 32'h380, 2, 16'h8001);
        exp_n = 0; add_exp(32'h380, 3);
        s = rx_cnt;
        do_kick;
        chk_frame(s, "R9 offset reset");
        pulse_irq_clear;
        fill(32'h3C0, 64);
        put_desc(0, 32'h3C0, 63, 16'h8001);
        exp_n = 0; add_exp(32'h3C0, 64);
        s = rx_cnt;
        do_kick;
        chk_frame(s, "R9 exact fill");
        chk(ctl_word(0) == 32'h00010044, "R9 full wb", ctl_word(0), 32'h00010044);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_single;
        t_multi;
        t_wrap;
        t_exhaust_clear;
        t_invalid;
        t_overflow;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule